// File: doc/BRIEF.md
# Zero-Turnaround Synchronous SRAM Core

This block is a synchronous static memory that accepts one read or write command on every rising clock edge. Reads and writes can follow each other in any order with no idle cycles between them. This works because write data arrives late, in the same bus slot where a read issued in that position would deliver its data. A static mode input selects one of two read paths. In flow-through mode the array output goes straight to the data pins one slot after the command. In pipelined mode the data passes through an output register and appears one slot later than that.

A command needs all three active-high chip selects. A command can open a four-beat burst, and each later advance cycle steps a two-bit offset through the low address bits, in linear or interleaved order. Byte writes use one enable per 9-bit byte. The output enable and the sleep input act without waiting for a clock edge. The output enable silences the data pins at once, and sleep keeps any new access from being accepted. A read that follows a write to the same address always returns the newest data, even if that write's data has not yet reached the array.

Top module: `turnless_sram`

## Requirements
- R1: A new command is accepted at a rising edge when `sleep` is low, `advance` is low and `selA`, `selB` and `selC` are all high. It is a write when `writeCmd` is 1 and a read when it is 0. A write never drives the data outputs.
- R2: With `pipeMode`=0, data for a read accepted at edge N is driven from just after edge N until edge N+1. Data for a write accepted at edge N is taken from `wrData` at edge N+1.
- R3: With `pipeMode`=1, data for a read accepted at edge N is driven from just after edge N+1 until edge N+2. Data for a write accepted at edge N is taken from `wrData` at edge N+2.
- R4: Reads and writes may be issued on consecutive edges in any order. A read returns the most recent data written to its address by any earlier command, including a write whose data has not yet been taken at the time of the read.
- R5: `byteWe` is sampled with each command. When bit i is 1, bits [9i+8:9i] of the word are written. Bytes whose enable is 0 keep their old contents.
- R6: An advance cycle (`advance`=1, `sleep`=0) during an open burst issues an access of the same direction as the command that opened the burst. The access goes to the same upper address bits. The low two bits become (start+k) mod 4 when `interleave`=0, and start XOR k when `interleave`=1, where k counts advances mod 4. The chip selects are ignored during an advance.
- R7: A cycle with `advance` low and any chip select low is a deselect. It starts no access and closes the burst. Accesses already in flight still complete. An advance with no open burst starts no access.
- R8: While `sleep` is high, no command and no advance is accepted. Accesses already in flight still complete.
- R9: When `outEnable` is low, `rdDrive` is 0 without waiting for a clock edge. `rdData` is 0 whenever `rdDrive` is 0.
- R10: After reset no access is in flight and `rdDrive` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all sampling on the rising edge |
| rstN | input | 1 | Asynchronous active-low reset of the control state |
| selA | input | 1 | Chip select, active high |
| selB | input | 1 | Chip select, active high |
| selC | input | 1 | Chip select, active high |
| advance | input | 1 | Continue the open burst |
| writeCmd | input | 1 | 1 = write, 0 = read, for a new command |
| addr | input | ADDR_W | Word address of a new command |
| byteWe | input | BYTES | Per-byte write enables, sampled with the command |
| wrData | input | BYTES*BYTE_W | Late write data |
| pipeMode | input | 1 | 1 = pipelined, 0 = flow-through (static) |
| interleave | input | 1 | 1 = interleaved burst order, 0 = linear (static) |
| sleep | input | 1 | Power-down; blocks new accesses |
| outEnable | input | 1 | Asynchronous output enable |
| rdData | output | BYTES*BYTE_W | Read data, 0 when not driven |
| rdDrive | output | 1 | Data pins are driven |

## Verification
In flow-through mode a read's result is due one edge after its command, and a write's data is due at that same edge. In pipelined mode both move to two edges after the command. The bench keeps an eight-entry slot schedule. Each accepted command writes its expected read value, or its write data, into the slot its latency points to. At each falling edge the bench first checks the outputs against the current slot and only then drives the inputs for the coming edge. The reference memory is updated in command order at issue time, so bypass cases appear as plain newest-data expectations.

// File: rtl/turnless_pkg.sv
package turnless_pkg;

  // Strobes handed from the control to the datapath each cycle.
  typedef struct packed {
    logic wrEn;       // commit a word (masked) into the array
    logic loadOut;    // capture the array word into the output register
    logic syncDrive;  // data pins should drive, before output-enable gating
  } strobe_t;

endpackage

// File: rtl/turnless_ctrl.sv
module turnless_ctrl
  import turnless_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int BYTES  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              selA,
  input  logic              selB,
  input  logic              selC,
  input  logic              advance,
  input  logic              writeCmd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTES-1:0]  byteWe,
  input  logic              pipeMode,
  input  logic              interleave,
  input  logic              sleep,
  output strobe_t           strobe,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [BYTES-1:0]  wrBe,
  output logic [ADDR_W-1:0] rdAddr,
  output logic [BYTES-1:0]  bypassBe
);

  localparam int OFS_W  = 2;
  localparam int HIGH_W = ADDR_W - OFS_W;
  localparam int STAGES = 2;

  typedef struct packed {
    logic              valid;
    logic              write;
    logic [ADDR_W-1:0] addr;
    logic [BYTES-1:0]  be;
  } stage_t;

  logic              selected, newCmd, deselCmd, advOk;
  logic              burstActive, burstWrite;
  logic [HIGH_W-1:0] burstHigh;
  logic [OFS_W-1:0]  burstStart, burstCnt, nextCnt, advOfs;
  stage_t            issue, wrStage;
  stage_t            stg [STAGES];

  assign selected = selA & selB & selC;
  assign newCmd   = !sleep && !advance && selected;
  assign deselCmd = !sleep && !advance && !selected;
  assign advOk    = !sleep && advance && burstActive;
  assign nextCnt  = burstCnt + OFS_W'(1);
  assign advOfs   = interleave ? (burstStart ^ nextCnt) : (burstStart + nextCnt);

  always_comb begin
    issue.valid = newCmd | advOk;
    issue.write = newCmd ? writeCmd : burstWrite;
    issue.addr  = newCmd ? addr : {burstHigh, advOfs};
    issue.be    = byteWe;
  end

  // Burst sequencer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      burstActive <= 1'b0;
      burstWrite  <= 1'b0;
      burstHigh   <= '0;
      burstStart  <= '0;
      burstCnt    <= '0;
    end else if (newCmd) begin
      burstActive <= 1'b1;
      burstWrite  <= writeCmd;
      burstHigh   <= addr[ADDR_W-1:OFS_W];
      burstStart  <= addr[OFS_W-1:0];
      burstCnt    <= '0;
    end else if (advOk) begin
      burstCnt    <= nextCnt;
    end else if (deselCmd) begin
      burstActive <= 1'b0;
    end
  end

  // Access pipeline: stage 0 holds the command of the last edge, stage 1 the one before
  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stg[s] <= '0;
        else if (s == 0) stg[s] <= issue;
        else stg[s] <= stg[s-1];
      end
    end
  endgenerate

  assign wrStage = pipeMode ? stg[1] : stg[0];
  assign wrAddr  = wrStage.addr;
  assign wrBe    = wrStage.be;
  assign rdAddr  = stg[0].addr;

  always_comb begin
    strobe.wrEn      = wrStage.valid & wrStage.write;
    strobe.loadOut   = stg[0].valid & !stg[0].write;
    strobe.syncDrive = pipeMode ? (stg[1].valid & !stg[1].write)
                                : (stg[0].valid & !stg[0].write);
  end

  // Pending pipelined write to the address being read: take its bytes from the bus
  assign bypassBe = (pipeMode && stg[1].valid && stg[1].write && stg[1].addr == stg[0].addr)
                    ? stg[1].be : '0;

endmodule

// File: rtl/turnless_dpath.sv
module turnless_dpath
  import turnless_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int BYTES  = 2,
  parameter int BYTE_W = 9
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  strobe_t                 strobe,
  input  logic [ADDR_W-1:0]       wrAddr,
  input  logic [BYTES-1:0]        wrBe,
  input  logic [ADDR_W-1:0]       rdAddr,
  input  logic [BYTES-1:0]        bypassBe,
  input  logic [BYTES*BYTE_W-1:0] wrData,
  input  logic                    pipeMode,
  input  logic                    outEnable,
  output logic [BYTES*BYTE_W-1:0] rdData,
  output logic                    rdDrive
);

  localparam int DATA_W = BYTES * BYTE_W;
  localparam int DEPTH  = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] memWord, readWord, outReg, syncWord;

  always_ff @(posedge clk) begin
    if (strobe.wrEn) begin
      for (int b = 0; b < BYTES; b++) begin
        if (wrBe[b]) mem[wrAddr][b*BYTE_W +: BYTE_W] <= wrData[b*BYTE_W +: BYTE_W];
      end
    end
  end

  assign memWord = mem[rdAddr];

  generate
    for (genvar b = 0; b < BYTES; b++) begin : g_merge
      assign readWord[b*BYTE_W +: BYTE_W] = bypassBe[b] ? wrData[b*BYTE_W +: BYTE_W]
                                                        : memWord[b*BYTE_W +: BYTE_W];
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outReg <= '0;
    else if (strobe.loadOut) outReg <= readWord;
  end

  assign syncWord = pipeMode ? outReg : readWord;
  assign rdDrive  = strobe.syncDrive & outEnable;
  assign rdData   = rdDrive ? syncWord : '0;

endmodule

// File: rtl/turnless_sram.sv
module turnless_sram
  import turnless_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int BYTES  = 2,
  parameter int BYTE_W = 9
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    selA,
  input  logic                    selB,
  input  logic                    selC,
  input  logic                    advance,
  input  logic                    writeCmd,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [BYTES-1:0]        byteWe,
  input  logic [BYTES*BYTE_W-1:0] wrData,
  input  logic                    pipeMode,
  input  logic                    interleave,
  input  logic                    sleep,
  input  logic                    outEnable,
  output logic [BYTES*BYTE_W-1:0] rdData,
  output logic                    rdDrive
);

  strobe_t           strobe;
  logic [ADDR_W-1:0] wrAddr, rdAddr;
  logic [BYTES-1:0]  wrBe, bypassBe;

  turnless_ctrl #(.ADDR_W(ADDR_W), .BYTES(BYTES)) u_ctrl (
    .clk(clk), .rstN(rstN), .selA(selA), .selB(selB), .selC(selC),
    .advance(advance), .writeCmd(writeCmd), .addr(addr), .byteWe(byteWe),
    .pipeMode(pipeMode), .interleave(interleave), .sleep(sleep),
    .strobe(strobe), .wrAddr(wrAddr), .wrBe(wrBe), .rdAddr(rdAddr), .bypassBe(bypassBe)
  );

  turnless_dpath #(.ADDR_W(ADDR_W), .BYTES(BYTES), .BYTE_W(BYTE_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrAddr(wrAddr), .wrBe(wrBe),
    .rdAddr(rdAddr), .bypassBe(bypassBe), .wrData(wrData), .pipeMode(pipeMode),
    .outEnable(outEnable), .rdData(rdData), .rdDrive(rdDrive)
  );

endmodule

// File: rtl/turnless_sram_chk.sv
module turnless_sram_chk (
  input logic clk,
  input logic rstN,
  input logic selA,
  input logic selB,
  input logic selC,
  input logic advance,
  input logic writeCmd,
  input logic sleep,
  input logic pipeMode,
  input logic outEnable,
  input logic rdDrive
);

  logic [1:0] age;  // saturates at 2: at least two edges since reset
  logic       rdCmd, wrCmd, deselCmd;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) age <= '0;
    else if (age != 2'd2) age <= age + 2'd1;
  end

  assign rdCmd    = !sleep && !advance && selA && selB && selC && !writeCmd;
  assign wrCmd    = !sleep && !advance && selA && selB && selC && writeCmd;
  assign deselCmd = !sleep && !advance && !(selA && selB && selC);

  a_r9_oe_silences: assert property (@(posedge clk) disable iff (!rstN)
    !outEnable |-> !rdDrive);

  a_r2_flow_read_due: assert property (@(posedge clk) disable iff (!rstN)
    (age == 2'd2 && !pipeMode && outEnable && $past(rdCmd)) |-> rdDrive);

  a_r3_pipe_read_due: assert property (@(posedge clk) disable iff (!rstN)
    (age == 2'd2 && pipeMode && outEnable && $past(rdCmd, 2)) |-> rdDrive);

  a_r1_write_no_drive: assert property (@(posedge clk) disable iff (!rstN)
    (age == 2'd2 && !pipeMode && $past(wrCmd)) |-> !rdDrive);

  a_r7_deselect_idle: assert property (@(posedge clk) disable iff (!rstN)
    (age == 2'd2 && !pipeMode && $past(deselCmd)) |-> !rdDrive);

  a_r8_sleep_flow: assert property (@(posedge clk) disable iff (!rstN)
    (age == 2'd2 && !pipeMode && $past(sleep)) |-> !rdDrive);

  a_r8_sleep_pipe: assert property (@(posedge clk) disable iff (!rstN)
    (age == 2'd2 && pipeMode && $past(sleep, 2)) |-> !rdDrive);

endmodule

bind turnless_sram turnless_sram_chk u_chk (.*);

// File: tb/turnless_sram_test.sv
module turnless_sram_test;

  localparam int AW = 6;
  localparam int NB = 2;
  localparam int BW = 9;
  localparam int DW = NB * BW;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          selA = 0, selB = 0, selC = 0, advance = 0, writeCmd = 0;
  logic [AW-1:0] addr = '0;
  logic [NB-1:0] byteWe = '0;
  logic [DW-1:0] wrData = '0;
  logic          pipeMode = 0, interleave = 0, sleep = 0, outEnable = 1;
  logic [DW-1:0] rdData;
  logic          rdDrive;

  always #5 clk = ~clk;

  turnless_sram #(.ADDR_W(AW), .BYTES(NB), .BYTE_W(BW)) uut (
    .clk(clk), .rstN(rstN), .selA(selA), .selB(selB), .selC(selC),
    .advance(advance), .writeCmd(writeCmd), .addr(addr), .byteWe(byteWe),
    .wrData(wrData), .pipeMode(pipeMode), .interleave(interleave), .sleep(sleep),
    .outEnable(outEnable), .rdData(rdData), .rdDrive(rdDrive)
  );

  int            checks = 0, errors = 0;
  string         curTag = "R1";
  logic [DW-1:0] refMem [1 << AW];
  int            slotKind [8];   // 0 none, 1 read due, 2 write data due
  logic [DW-1:0] slotVal [8];
  int            slot = 0, lat = 1, genSeq = 1;
  bit            bActive = 0, bWrite = 0;
  logic [AW-3:0] bHigh = '0;
  logic [1:0]    bStart = '0, bCnt = '0;

  task automatic chk(string tag, logic [DW:0] act, logic [DW:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s drive/data actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(bit adv, bit we, logic [AW-1:0] a, logic [NB-1:0] be,
                      logic [2:0] sel, bit slp, bit oe);
    int            idx, tidx;
    bit            doIt, isW;
    logic [AW-1:0] ea;
    logic [1:0]    ofs;
    logic [DW-1:0] wv;
    logic [DW:0]   exp;
    @(negedge clk);
    outEnable = oe;
    #1;
    idx = slot % 8;
    exp = (slotKind[idx] == 1 && oe) ? {1'b1, slotVal[idx]} : '0;
    chk(oe ? curTag : "R9", {rdDrive, rdData}, exp);
    wrData = (slotKind[idx] == 2) ? slotVal[idx] : '0;
    slotKind[idx] = 0;
    advance = adv; writeCmd = we; addr = a; byteWe = be;
    {selA, selB, selC} = sel; sleep = slp;
    doIt = 0; isW = 0; ea = '0;
    if (!slp) begin
      if (!adv && sel == 3'b111) begin
        bActive = 1; bWrite = we; bHigh = a[AW-1:2]; bStart = a[1:0]; bCnt = '0;
        doIt = 1; isW = we; ea = a;
      end else if (!adv) begin
        bActive = 0;
      end else if (bActive) begin
        bCnt = bCnt + 2'd1;
        ofs = interleave ? (bStart ^ bCnt) : (bStart + bCnt);
        ea = {bHigh, ofs}; isW = bWrite; doIt = 1;
      end
    end
    if (doIt) begin
      tidx = (slot + lat) % 8;
      if (isW) begin
        wv = DW'(genSeq * 40503 + 11);
        genSeq++;
        for (int b = 0; b < NB; b++) if (be[b]) refMem[ea][b*BW +: BW] = wv[b*BW +: BW];
        slotKind[tidx] = 2; slotVal[tidx] = wv;
      end else begin
        slotKind[tidx] = 1; slotVal[tidx] = refMem[ea];
      end
    end
    slot++;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, '0, '0, 3'b000, 0, 1);
  endtask

  task automatic runMode(bit pm);
    @(negedge clk);
    rstN = 0; pipeMode = pm; lat = pm ? 2 : 1;
    {selA, selB, selC} = 3'b000; advance = 0; sleep = 0; outEnable = 1;
    for (int i = 0; i < 8; i++) slotKind[i] = 0;
    bActive = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R10", {rdDrive, rdData}, '0);
    rstN = 1;
    // R1 and R2/R3: full write sweep then full read sweep
    curTag = "R1";
    for (int i = 0; i < 64; i++) step(0, 1, AW'(i), 2'b11, 3'b111, 0, 1);
    curTag = pm ? "R3" : "R2";
    for (int i = 0; i < 64; i++) step(0, 0, AW'(63 - i), 2'b00, 3'b111, 0, 1);
    idle(3);
    // R4: write then immediate read of the same address, and read-write-read
    curTag = "R4";
    for (int i = 0; i < 64; i++) begin
      step(0, 1, AW'(i * 7), 2'b11, 3'b111, 0, 1);
      step(0, 0, AW'(i * 7), 2'b00, 3'b111, 0, 1);
    end
    for (int i = 0; i < 16; i++) begin
      step(0, 0, AW'(i * 3), 2'b00, 3'b111, 0, 1);
      step(0, 1, AW'(i * 3), 2'b11, 3'b111, 0, 1);
      step(0, 0, AW'(i * 3), 2'b00, 3'b111, 0, 1);
    end
    idle(3);
    // R5: every byte-enable pattern, read back at once and later
    curTag = "R5";
    for (int k = 0; k < 16; k++) begin
      step(0, 1, AW'(k + 20), NB'(k % 4), 3'b111, 0, 1);
      step(0, 0, AW'(k + 20), 2'b00, 3'b111, 0, 1);
    end
    for (int k = 0; k < 16; k++) step(0, 0, AW'(k + 20), 2'b00, 3'b111, 0, 1);
    idle(3);
    // R6: bursts in both orders from every start offset; selects low during advances
    curTag = "R6";
    for (int o = 0; o < 2; o++) begin
      interleave = o[0];
      for (int s = 0; s < 4; s++) begin
        step(0, 1, AW'(36 + s), 2'b11, 3'b111, 0, 1);
        for (int j = 0; j < 5; j++) step(1, 0, '0, 2'b11, 3'b000, 0, 1);
        step(0, 0, AW'(36 + s), 2'b00, 3'b111, 0, 1);
        for (int j = 0; j < 5; j++) step(1, 1, '0, 2'b00, 3'b010, 0, 1);
        idle(2);
      end
    end
    // R7: partial selects and advance with no open burst start nothing
    curTag = "R7";
    for (int m = 0; m < 7; m++) begin
      step(0, 1, AW'(5), 2'b11, 3'(m), 0, 1);
      step(0, 0, AW'(9), 2'b00, 3'(m), 0, 1);
      step(1, 1, '0, 2'b11, 3'b111, 0, 1);
      step(0, 0, AW'(5), 2'b00, 3'b111, 0, 1);
    end
    idle(3);
    // R8: sleep blocks commands and advances; a read in flight still completes
    curTag = "R8";
    step(0, 0, AW'(12), 2'b00, 3'b111, 0, 1);
    step(0, 1, AW'(12), 2'b11, 3'b111, 1, 1);
    step(1, 0, '0, 2'b11, 3'b111, 1, 1);
    step(1, 0, '0, 2'b11, 3'b111, 0, 1);
    step(0, 0, AW'(12), 2'b00, 3'b111, 0, 1);
    idle(3);
    // R9: output enable toggled while reads stream
    curTag = "R9";
    for (int i = 0; i < 12; i++) step(0, 0, AW'(i), 2'b00, 3'b111, 0, i[0]);
    idle(3);
  endtask

  initial begin
    for (int i = 0; i < (1 << AW); i++) refMem[i] = '0;
    runMode(0);
    runMode(1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R10 watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule